// File: doc/BRIEF.md
# Serial Flash Execute-In-Place Read Controller

This block lets a processor fetch words straight out of an external serial flash as if it were memory. When the processor asks for a word, the block runs one complete flash read over a one-bit serial link and returns the result. That read is a command byte, a 24-bit byte address, and then 32 data bits clocked back. The processor sees a plain request and acknowledge exchange. It never has to drive the serial pins itself.

A single 32-bit control word holds all the settings. It sets the enable, the serial clock rate (a coarse power-of-two prescaler times a fine divider, or a maximum-rate mode), the clock polarity and phase, the read command byte, and whether the chip select pin is allowed to go low. Two read-only status bits show whether the serial engine is active and whether a processor read is still waiting for its answer. Clearing the enable aborts the transfer on the spot. A read issued while the block is disabled gets a bus error.

Top module: `xip_flash_ctrl`

## Requirements
- R1: After reset the chip select is high, the serial clock is low, the control word reads as zero and neither acknowledge nor error is asserted.
- R2: The writable control fields are enable bit 0, prescaler bits 3:1, polarity bit 4, phase bit 5, command bits 20:13, chip-select gate bit 21, high-speed bit 22 and fine divider bits 26:23. They read back as written, and bits 12:6 and 29:27 read as zero.
- R3: Each read holds chip select low for one window of exactly 64 serial clock cycles. Within it the block sends the command byte, then the 24-bit address most significant bit first, then receives 32 data bits.
- R4: The first received byte lands in data bits 7:0, the second in 15:8, the third in 23:16 and the fourth in 31:24.
- R5: The serial clock idles at the polarity bit. With phase 0 the input is sampled on the leading edge and the output changes on the trailing edge. With phase 1 the output changes on the leading edge and the input is sampled on the trailing edge.
- R6: Each serial clock half-period lasts (divider + 1) × 2^prescaler system clock cycles. In high-speed mode it lasts one cycle whatever the prescaler and divider hold.
- R7: With the chip-select gate bit clear, a read still runs and is acknowledged, but the chip select stays high.
- R8: A read request while the enable bit is clear gets a one-cycle error response and causes no serial activity.
- R9: Clearing the enable during a read puts the chip select high by the following cycle, and that read is never acknowledged.
- R10: Control bit 30 reads 1 while the serial engine is active, and bit 31 reads 1 while a processor read is pending. Both read 0 when the block is quiet.
- R11: Between two back-to-back reads the chip select stays high for at least two half-periods.
- R12: The acknowledge is a single-cycle pulse. It comes only after the last data bit has been sampled, and it is never asserted in the same cycle as the error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ctrl_we | input | 1 | Control word write strobe |
| ctrl_wdata | input | 32 | Control word write value |
| ctrl_rdata | output | 32 | Control word and status readback |
| rd_req | input | 1 | Read request, held until acknowledge or error |
| rd_addr | input | 24 | Flash byte address of the read |
| rd_ack | output | 1 | Read done, data valid |
| rd_err | output | 1 | Read refused (block disabled) |
| rd_data | output | 32 | Read data word |
| spi_csn | output | 1 | Flash chip select, active low |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to flash |
| spi_miso | input | 1 | Serial data from flash |

## Verification
The bench checks all four polarity and phase pairs against a flash model that samples and drives on the edges the selected mode defines. A design that swapped the sampling and driving edges would return shifted words and wrong command or address bytes. It times the half-period at a slow divider setting and in high-speed mode, and it measures the chip-select gap between back-to-back reads, so an off-by-one in the divider or a gap that is too short shows up as a wrong cycle count. It also aborts a read partway through by clearing the enable. A design that kept running after the abort would leave chip select low, or would acknowledge the read instead of refusing it.

// File: rtl/xip_pkg.sv
package xip_pkg;
  localparam int XIP_CMD_W  = 8;
  localparam int XIP_ADDR_W = 24;
  localparam int XIP_DATA_W = 32;
  localparam int XIP_PRSC_W = 3;
  localparam int XIP_CDIV_W = 4;
  localparam int XIP_REG_W  = 32;

  // Writable control bits; everything else reads as zero.
  localparam logic [XIP_REG_W-1:0] XIP_WMASK = 32'h07FF_E03F;

  typedef struct packed {
    logic                  en;
    logic [XIP_PRSC_W-1:0] prsc;
    logic                  cpol;
    logic                  cpha;
    logic [XIP_CMD_W-1:0]  cmd;
    logic                  cs_en;
    logic                  hs;
    logic [XIP_CDIV_W-1:0] cdiv;
  } xip_ctrl_t;

  typedef enum logic [1:0] {
    PHY_IDLE,
    PHY_LEAD,
    PHY_SHIFT,
    PHY_GAP
  } phy_state_t;

  function automatic xip_ctrl_t ctrl_decode(input logic [XIP_REG_W-1:0] r);
    xip_ctrl_t c;
    c.en    = r[0];
    c.prsc  = r[3:1];
    c.cpol  = r[4];
    c.cpha  = r[5];
    c.cmd   = r[20:13];
    c.cs_en = r[21];
    c.hs    = r[22];
    c.cdiv  = r[26:23];
    return c;
  endfunction
endpackage

// File: rtl/xip_ctrl_reg.sv
module xip_ctrl_reg
  import xip_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 we,
  input  logic [XIP_REG_W-1:0] wdata,
  input  logic                 phy_busy,
  input  logic                 xip_busy,
  output logic [XIP_REG_W-1:0] rdata,
  output xip_ctrl_t            ctrl
);
  logic [XIP_REG_W-1:0] reg_q;

  // R2: only the defined fields are stored
  always_ff @(posedge clk) begin
    if (rst)     reg_q <= '0;
    else if (we) reg_q <= wdata & XIP_WMASK;
  end

  // R10: live status in the two top bits
  always_comb begin
    rdata = {xip_busy, phy_busy, reg_q[XIP_REG_W-3:0]};
    ctrl  = ctrl_decode(reg_q);
  end
endmodule

// File: rtl/xip_sck_gen.sv
module xip_sck_gen #(
  parameter int PRSC_W = 3,
  parameter int CDIV_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              hs,
  input  logic [PRSC_W-1:0] prsc,
  input  logic [CDIV_W-1:0] cdiv,
  output logic              tick
);
  localparam int CNT_W = CDIV_W + (1 << PRSC_W);

  logic [CNT_W-1:0] cnt, half, limit;

  // R6: half-period = (cdiv+1) << prsc, or one cycle in high-speed mode
  always_comb begin
    half  = (CNT_W'(cdiv) + CNT_W'(1)) << prsc;
    limit = hs ? '0 : half - CNT_W'(1);
    tick  = run && (cnt >= limit);
  end

  always_ff @(posedge clk) begin
    if (rst || !run)       cnt <= '0;
    else if (cnt >= limit) cnt <= '0;
    else                   cnt <= cnt + CNT_W'(1);
  end

  p_no_tick_idle_r6: assert property (@(posedge clk) disable iff (rst)
    !run |=> (cnt == '0));
endmodule

// File: rtl/xip_spi_phy.sv
module xip_spi_phy
  import xip_pkg::*;
#(
  parameter int FRAME_W = 64,
  parameter int RX_W    = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               abort,
  input  logic               start,
  input  logic [FRAME_W-1:0] frame,
  input  logic               cpol,
  input  logic               cpha,
  input  logic               cs_en,
  input  logic               tick,
  input  logic               miso,
  output logic               run,
  output logic               busy,
  output logic               done,
  output logic [RX_W-1:0]    rx,
  output logic               sck,
  output logic               csn,
  output logic               mosi
);
  localparam int BIT_W = $clog2(FRAME_W);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(FRAME_W - 1);

  phy_state_t         st;
  logic [FRAME_W-1:0] tx;
  logic [BIT_W-1:0]   bitcnt;
  logic               trail;
  logic               gap_half;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= PHY_IDLE;
      tx       <= '0;
      rx       <= '0;
      bitcnt   <= '0;
      trail    <= 1'b0;
      gap_half <= 1'b0;
      sck      <= 1'b0;
      mosi     <= 1'b0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      if (abort) begin
        // R9: drop the transfer at once
        st  <= PHY_IDLE;
        sck <= cpol;
      end else begin
        case (st)
          PHY_IDLE: begin
            sck <= cpol;
            if (start) begin
              st     <= PHY_LEAD;
              bitcnt <= '0;
              trail  <= 1'b0;
              if (!cpha) begin
                mosi <= frame[FRAME_W-1];
                tx   <= frame << 1;
              end else begin
                tx   <= frame;
              end
            end
          end
          PHY_LEAD: begin
            if (tick) st <= PHY_SHIFT;
          end
          PHY_SHIFT: begin
            if (tick) begin
              if (!trail) begin
                sck   <= ~cpol;
                trail <= 1'b1;
                if (cpha) begin
                  mosi <= tx[FRAME_W-1];
                  tx   <= tx << 1;
                end else begin
                  rx <= {rx[RX_W-2:0], miso};
                end
              end else begin
                sck   <= cpol;
                trail <= 1'b0;
                if (cpha) begin
                  rx <= {rx[RX_W-2:0], miso};
                end else if (bitcnt != LAST_BIT) begin
                  mosi <= tx[FRAME_W-1];
                  tx   <= tx << 1;
                end
                if (bitcnt == LAST_BIT) begin
                  st       <= PHY_GAP;
                  gap_half <= 1'b0;
                  done     <= 1'b1;
                end else begin
                  bitcnt <= bitcnt + BIT_W'(1);
                end
              end
            end
          end
          PHY_GAP: begin
            // R11: chip select high for two half-periods
            if (tick) begin
              if (gap_half) st <= PHY_IDLE;
              else          gap_half <= 1'b1;
            end
          end
          default: st <= PHY_IDLE;
        endcase
      end
    end
  end

  always_comb begin
    busy = (st != PHY_IDLE);
    run  = busy;
    csn  = ~(cs_en && (st == PHY_LEAD || st == PHY_SHIFT));
  end

  p_abort_csn_r9: assert property (@(posedge clk) disable iff (rst)
    abort |=> csn);
  p_done_pulse_r12: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  p_sck_idle_r5: assert property (@(posedge clk) disable iff (rst)
    (st == PHY_IDLE) |=> (sck == $past(cpol)));
endmodule

// File: rtl/xip_flash_ctrl.sv
module xip_flash_ctrl
  import xip_pkg::*;
#(
  parameter int ADDR_W = XIP_ADDR_W,
  parameter int DATA_W = XIP_DATA_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 ctrl_we,
  input  logic [XIP_REG_W-1:0] ctrl_wdata,
  output logic [XIP_REG_W-1:0] ctrl_rdata,
  input  logic                 rd_req,
  input  logic [ADDR_W-1:0]    rd_addr,
  output logic                 rd_ack,
  output logic                 rd_err,
  output logic [DATA_W-1:0]    rd_data,
  output logic                 spi_csn,
  output logic                 spi_sck,
  output logic                 spi_mosi,
  input  logic                 spi_miso
);
  localparam int FRAME_W = XIP_CMD_W + ADDR_W + DATA_W;
  localparam int NBYTES  = DATA_W / 8;

  xip_ctrl_t          ctrl;
  logic               phy_busy, phy_run, phy_done, tick, start, busy_q;
  logic [DATA_W-1:0]  phy_rx, swapped;
  logic [FRAME_W-1:0] frame;

  xip_ctrl_reg u_reg (
    .clk      (clk),
    .rst      (rst),
    .we       (ctrl_we),
    .wdata    (ctrl_wdata),
    .phy_busy (phy_busy),
    .xip_busy (busy_q),
    .rdata    (ctrl_rdata),
    .ctrl     (ctrl)
  );

  xip_sck_gen #(.PRSC_W(XIP_PRSC_W), .CDIV_W(XIP_CDIV_W)) u_sck (
    .clk  (clk),
    .rst  (rst),
    .run  (phy_run),
    .hs   (ctrl.hs),
    .prsc (ctrl.prsc),
    .cdiv (ctrl.cdiv),
    .tick (tick)
  );

  xip_spi_phy #(.FRAME_W(FRAME_W), .RX_W(DATA_W)) u_phy (
    .clk   (clk),
    .rst   (rst),
    .abort (!ctrl.en),
    .start (start),
    .frame (frame),
    .cpol  (ctrl.cpol),
    .cpha  (ctrl.cpha),
    .cs_en (ctrl.cs_en),
    .tick  (tick),
    .miso  (spi_miso),
    .run   (phy_run),
    .busy  (phy_busy),
    .done  (phy_done),
    .rx    (phy_rx),
    .sck   (spi_sck),
    .csn   (spi_csn),
    .mosi  (spi_mosi)
  );

  // R3: command, address, then room for the data phase
  assign frame = {ctrl.cmd, rd_addr, {DATA_W{1'b0}}};

  // R4: first byte received goes to the lowest byte lane
  for (genvar i = 0; i < NBYTES; i++) begin : g_swap
    assign swapped[8*i +: 8] = phy_rx[DATA_W-8-8*i +: 8];
  end

  assign start = !busy_q && rd_req && ctrl.en && !phy_busy && !rd_ack && !rd_err;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b0;
      rd_ack  <= 1'b0;
      rd_err  <= 1'b0;
      rd_data <= '0;
    end else begin
      rd_ack <= 1'b0;
      rd_err <= 1'b0;
      if (!busy_q) begin
        if (rd_req && !rd_ack && !rd_err && !ctrl.en) rd_err <= 1'b1;  // R8
        else if (start) busy_q <= 1'b1;
      end else if (!ctrl.en) begin
        busy_q <= 1'b0;                                               // R9
      end else if (phy_done) begin
        busy_q  <= 1'b0;
        rd_ack  <= 1'b1;
        rd_data <= swapped;
      end
    end
  end

  p_ack_err_excl_r12: assert property (@(posedge clk) disable iff (rst)
    !(rd_ack && rd_err));
  p_ack_after_done_r12: assert property (@(posedge clk) disable iff (rst)
    rd_ack |-> $past(phy_done));
  p_err_disabled_r8: assert property (@(posedge clk) disable iff (rst)
    rd_err |-> $past(!ctrl.en));
endmodule

// File: tb/xip_flash_ctrl_tb.sv
module xip_flash_ctrl_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ctrl_we = 1'b0;
  logic [31:0] ctrl_wdata = '0;
  logic [31:0] ctrl_rdata;
  logic        rd_req = 1'b0;
  logic [23:0] rd_addr = '0;
  logic        rd_ack, rd_err;
  logic [31:0] rd_data;
  logic        spi_csn, spi_sck, spi_mosi;
  logic        miso_m = 1'b0;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xip_flash_ctrl u_dut (
    .clk(clk), .rst(rst), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
    .ctrl_rdata(ctrl_rdata), .rd_req(rd_req), .rd_addr(rd_addr),
    .rd_ack(rd_ack), .rd_err(rd_err), .rd_data(rd_data),
    .spi_csn(spi_csn), .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(miso_m)
  );

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  function automatic logic [7:0] mem(input logic [23:0] a);
    return a[7:0] ^ (a[15:8] + 8'h3C);
  endfunction

  function automatic logic [31:0] word_at(input logic [23:0] a);
    return {mem(a + 24'd3), mem(a + 24'd2), mem(a + 24'd1), mem(a)};
  endfunction

  // ---------------- flash model ----------------
  bit          mcpol = 0, mcpha = 0;
  logic        prev_csn = 1'b1, prev_sck = 1'b0;
  logic [31:0] sh = '0;
  int          mcnt = 0, lead_cnt = 0, cs_falls = 0;
  logic [7:0]  cmd_got = '0;
  logic [23:0] addr_got = '0;

  always @(spi_sck or spi_csn) begin
    if (spi_sck !== prev_sck) begin
      prev_sck = spi_sck;
      if (prev_csn === 1'b0) begin
        bit lead;
        lead = (spi_sck != mcpol);
        if (lead) lead_cnt++;
        if (lead ^ mcpha) begin
          sh = {sh[30:0], spi_mosi};
          mcnt++;
          if (mcnt == 8)  cmd_got  = sh[7:0];
          if (mcnt == 32) addr_got = sh[23:0];
        end else if (mcnt >= 32 && mcnt < 64) begin
          int d;
          logic [7:0] b;
          d = mcnt - 32;
          b = mem(addr_got + 24'(d / 8));
          miso_m = b[7 - (d % 8)];
        end
      end
    end
    if (spi_csn !== prev_csn) begin
      prev_csn = spi_csn;
      if (spi_csn === 1'b0) begin
        mcnt = 0; lead_cnt = 0; sh = '0; miso_m = 1'b0; cs_falls++;
      end else begin
        miso_m = 1'b0;
      end
    end
  end

  // ------------- timing monitors -------------
  logic last_sck = 1'b0;
  bit   h_seen = 0;
  int   h_run = 0, h_min = 1 << 30, h_max = 0;
  int   hi_run = 0, gap_min = 1 << 30;

  always @(negedge clk) begin
    if (spi_csn === 1'b0) begin
      if (spi_sck !== last_sck) begin
        if (h_seen) begin
          if (h_run + 1 < h_min) h_min = h_run + 1;
          if (h_run + 1 > h_max) h_max = h_run + 1;
        end
        h_seen = 1; h_run = 0;
      end else h_run++;
      if (hi_run > 0 && hi_run < gap_min) gap_min = hi_run;
      hi_run = 0;
    end else begin
      h_seen = 0;
      hi_run++;
    end
    last_sck = spi_sck;
  end

  // ---------------- scoreboard ----------------
  typedef struct {
    bit          err;
    logic [31:0] data;
  } exp_t;
  exp_t exp_q[$];

  always @(negedge clk) begin
    if (!rst && (rd_ack || rd_err)) begin
      if (exp_q.size() == 0) begin
        chk(0, "R12", "unexpected response", {30'b0, rd_err, rd_ack}, 32'h0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(rd_err == e.err, "R8", "error flag", 32'(rd_err), 32'(e.err));
        chk(rd_ack == !e.err, "R12", "ack flag", 32'(rd_ack), 32'(!e.err));
        if (!e.err) chk(rd_data == e.data, "R4", "read data", rd_data, e.data);
      end
    end
  end

  // ---------------- driver ----------------
  function automatic logic [31:0] cfg(bit en, int prsc, bit cpol, bit cpha,
                                      logic [7:0] cmd, bit csen, bit hs, int cdiv);
    return {5'b0, 4'(cdiv), hs, csen, cmd, 7'b0, cpha, cpol, 3'(prsc), en};
  endfunction

  task automatic wr_ctrl(input logic [31:0] v);
    @(negedge clk);
    ctrl_we = 1'b1; ctrl_wdata = v;
    @(negedge clk);
    ctrl_we = 1'b0;
    mcpol = v[4]; mcpha = v[5];
  endtask

  task automatic do_read(input logic [23:0] a, input bit err, input bit zero);
    exp_t e;
    e.err = err;
    e.data = zero ? 32'h0 : word_at(a);
    exp_q.push_back(e);
    @(negedge clk);
    rd_req = 1'b1; rd_addr = a;
    do @(negedge clk); while (!(rd_ack || rd_err));
    rd_req = 1'b0;
  endtask

  task automatic reset_meas();
    h_min = 1 << 30; h_max = 0; gap_min = 1 << 30;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    chk(spi_csn == 1'b1, "R1", "csn after reset", 32'(spi_csn), 32'h1);
    chk(spi_sck == 1'b0, "R1", "sck after reset", 32'(spi_sck), 32'h0);
    chk(ctrl_rdata == 32'h0, "R1", "ctrl after reset", ctrl_rdata, 32'h0);
    chk(!rd_ack && !rd_err, "R1", "no response", {30'b0, rd_err, rd_ack}, 32'h0);

    // R2
    wr_ctrl(32'hFFFF_FFFF);
    chk(ctrl_rdata == 32'h07FF_E03F, "R2", "field mask", ctrl_rdata, 32'h07FF_E03F);
    wr_ctrl(cfg(1, 5, 0, 1, 8'hA5, 1, 0, 9) & 32'h3FFF_FFFE);
    chk(ctrl_rdata == cfg(0, 5, 0, 1, 8'hA5, 1, 0, 9), "R2", "readback", ctrl_rdata,
        cfg(0, 5, 0, 1, 8'hA5, 1, 0, 9));

    // R3 R4 R12 R6 high speed, mode 0
    wr_ctrl(cfg(1, 0, 0, 0, 8'h03, 1, 1, 0));
    reset_meas();
    do_read(24'h000104, 0, 0);
    chk(cmd_got == 8'h03, "R3", "command byte", 32'(cmd_got), 32'h03);
    chk(addr_got == 24'h000104, "R3", "address", 32'(addr_got), 32'h000104);
    chk(lead_cnt == 64, "R3", "clock count", 32'(lead_cnt), 32'd64);
    chk(mcnt == 64, "R12", "bits sampled at ack", 32'(mcnt), 32'd64);
    chk(h_min == 1 && h_max == 1, "R6", "high-speed half period", 32'(h_max), 32'd1);
    chk(spi_sck == 1'b0, "R5", "idle level mode 0", 32'(spi_sck), 32'h0);

    // R5: other three modes
    for (int m = 1; m < 4; m++) begin
      logic [23:0] a;
      a = 24'hABCDE0 + 24'(m * 7);
      wr_ctrl(cfg(1, 0, m[1], m[0], 8'h0B, 1, 0, 0));
      do_read(a, 0, 0);
      chk(cmd_got == 8'h0B, "R5", "command in mode", 32'(cmd_got), 32'h0B);
      chk(addr_got == a, "R5", "address in mode", 32'(addr_got), 32'(a));
      chk(spi_sck == m[1], "R5", "idle level", 32'(spi_sck), 32'(m[1]));
    end

    // R6: slow divider, and high-speed overriding prescaler
    wr_ctrl(cfg(1, 2, 0, 0, 8'h03, 1, 0, 1));
    reset_meas();
    do_read(24'h123456, 0, 0);
    chk(h_min == 8 && h_max == 8, "R6", "half period (1+1)<<2", 32'(h_max), 32'd8);
    wr_ctrl(cfg(1, 1, 0, 0, 8'h03, 1, 1, 2));
    reset_meas();
    do_read(24'h00FF00, 0, 0);
    chk(h_min == 1 && h_max == 1, "R6", "high speed ignores prescaler", 32'(h_max), 32'd1);

    // R11: back-to-back gap, half period 2
    wr_ctrl(cfg(1, 1, 1, 1, 8'h03, 1, 0, 0));
    do_read(24'h200000, 0, 0);
    reset_meas();
    do_read(24'h200004, 0, 0);
    chk(gap_min >= 4, "R11", "chip select gap", 32'(gap_min), 32'd4);

    // R7: gate off
    begin
      int f0;
      f0 = cs_falls;
      wr_ctrl(cfg(1, 0, 0, 0, 8'h03, 0, 1, 0));
      do_read(24'h000010, 0, 1);
      chk(cs_falls == f0, "R7", "csn never low", 32'(cs_falls), 32'(f0));
    end

    // R8: disabled read
    begin
      int f0;
      f0 = cs_falls;
      wr_ctrl(cfg(0, 0, 0, 0, 8'h03, 1, 1, 0));
      do_read(24'h000020, 1, 0);
      chk(cs_falls == f0, "R8", "no serial activity", 32'(cs_falls), 32'(f0));
    end

    // R9: abort mid-read
    wr_ctrl(cfg(1, 0, 0, 0, 8'h03, 1, 1, 0));
    fork
      do_read(24'h000030, 1, 0);
      begin
        repeat (40) @(negedge clk);
        chk(spi_csn == 1'b0, "R9", "transfer running", 32'(spi_csn), 32'h0);
        wr_ctrl(cfg(0, 0, 0, 0, 8'h03, 1, 1, 0));
        @(posedge clk);
        @(negedge clk);
        chk(spi_csn == 1'b1, "R9", "csn after abort", 32'(spi_csn), 32'h1);
      end
    join

    // R10: status bits
    wr_ctrl(cfg(1, 0, 0, 0, 8'h03, 1, 1, 0));
    fork
      do_read(24'h000040, 0, 0);
      begin
        repeat (10) @(negedge clk);
        chk(ctrl_rdata[31:30] == 2'b11, "R10", "busy bits mid read",
            32'(ctrl_rdata[31:30]), 32'h3);
      end
    join
    repeat (20) @(negedge clk);
    chk(ctrl_rdata[31:30] == 2'b00, "R10", "busy bits quiet",
        32'(ctrl_rdata[31:30]), 32'h0);
    chk(exp_q.size() == 0, "R12", "all responses seen", 32'(exp_q.size()), 32'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule